// File: doc/BRIEF.md
# Serial receive interrupt source selector

This block turns one of four receiver events into a single-clock interrupt pulse for a serial port receiver. A two-bit mode input picks the source: a new received word (the ready flag rising), a 16-channel block boundary or end of frame while multichannel selection is on, a new frame-sync pulse, or a frame-sync error flag becoming set. The receiver's shifter, its channel counter and the register that holds the mode live outside. The block only sees their flags and strobes.

The frame-sync input is asynchronous. It goes through a flop synchronizer and a rising-edge detector, so each external pulse gives one interrupt. That source stays active while the receiver reset is held. The other three sources are muted by the receiver reset. Every edge detector keeps tracking its input whatever mode is selected, so a mode change cannot release a stale edge. Registered copies of the ready and sync-error flags are always readable.

Top module: `rx_int_sel`

## Requirements
- R1: While `rst` is high, `rint`, `rdy_stat` and `serr_stat` are 0 one cycle later, and all edge history is cleared to 0.
- R2: With `mode` = 2'b00 and `rx_rst` low, `rint` is high for exactly the cycle after the clock edge at which `rx_ready` is sampled 1, having been sampled 0 at the previous edge.
- R3: With `mode` = 2'b01, `mc_en` high and `rx_rst` low, `rint` pulses one cycle after an edge at which `eof` is high. It also pulses one cycle after an edge at which `chan_idx` differs from its previously sampled value while that previous value has its low four bits equal to 4'hF. A boundary and `eof` in the same cycle give one single-cycle pulse.
- R4: With `mode` = 2'b01 and `mc_en` low, `rint` stays 0 whatever `eof` and `chan_idx` do.
- R5: With `mode` = 2'b10, `fs_async` passes through two synchronizer flops and a rising-edge detector. `rint` is high in the cycle after edge n when `fs_async` was sampled 1 at edge n-2 and 0 at edge n-3. This holds whatever the value of `rx_rst`, and a long high pulse gives one interrupt.
- R6: With `mode` = 2'b11 and `rx_rst` low, `rint` pulses for one cycle after the edge at which `sync_err` is sampled 1, having been 0 at the previous edge.
- R7: With `rx_rst` high and `mode` other than 2'b10, `rint` is 0 in the next cycle. The edge history keeps tracking, so releasing `rx_rst` while a flag is already high gives no pulse.
- R8: An edge that occurred while a different mode was selected is not reported after switching to its mode.
- R9: In every mode and during `rx_rst`, `rdy_stat` and `serr_stat` equal `rx_ready` and `sync_err` as sampled at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| mode | input | 2 | Interrupt source: 00 word, 01 block/frame, 10 frame sync, 11 sync error |
| rx_rst | input | 1 | Receiver held in reset |
| rx_ready | input | 1 | Receive-ready status flag |
| sync_err | input | 1 | Frame-sync error status flag |
| fs_async | input | 1 | Asynchronous receive frame-sync input |
| mc_en | input | 1 | Multichannel selection enabled |
| chan_idx | input | IDX_W | Current channel index |
| eof | input | 1 | End-of-frame strobe |
| rint | output | 1 | Receive interrupt pulse |
| rdy_stat | output | 1 | Registered receive-ready status |
| serr_stat | output | 1 | Registered sync-error status |

## Verification
The bench sweeps all four modes with random flags, frame-sync pulses of varying length and a channel index that advances or stalls across block edges. It predicts every cycle's interrupt from sampled input history. The directed parts cover the following cases, with the failure each would expose:
- A frame sync arriving under receiver reset, which a design that gates that source would drop.
- Releasing receiver reset with the ready flag already high, which a design that froze its history would report as a false edge.
- A mode switch after an edge seen in another mode, which would give a spurious pulse.
- A boundary coinciding with end of frame, which would give a double-length pulse.
- A stalled index on channel 15, which an over-eager boundary detector would flag.

// File: rtl/rxi_pkg.sv
package rxi_pkg;
  typedef enum logic [1:0] {
    RXI_WORD  = 2'b00,
    RXI_BLOCK = 2'b01,
    RXI_FSYNC = 2'b10,
    RXI_ERR   = 2'b11
  } rxi_mode_e;
endpackage

// File: rtl/rxi_rise.sv
module rxi_rise (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic rise
);
  logic d_q;

  always_ff @(posedge clk) begin
    if (rst) d_q <= 1'b0;
    else     d_q <= d;
  end

  assign rise = d & ~d_q;
endmodule

// File: rtl/rxi_fs_sync.sv
module rxi_fs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_in,
  output logic fs_rise
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= fs_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  // chain[STAGES-1] is the synchronized level, chain[STAGES] its last value
  assign fs_rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/rxi_blk_mark.sv
module rxi_blk_mark #(
  parameter int IDX_W    = 7,
  parameter int BLK_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  output logic             crossed
);
  localparam logic [BLK_LOG2-1:0] LAST = {BLK_LOG2{1'b1}};
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx;
  end

  assign crossed = (idx_q[BLK_LOG2-1:0] == LAST) && (idx != idx_q);
endmodule

// File: rtl/rx_int_sel.sv
module rx_int_sel #(
  parameter int IDX_W       = 7,
  parameter int BLK_LOG2    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             rx_rst,
  input  logic             rx_ready,
  input  logic             sync_err,
  input  logic             fs_async,
  input  logic             mc_en,
  input  logic [IDX_W-1:0] chan_idx,
  input  logic             eof,
  output logic             rint,
  output logic             rdy_stat,
  output logic             serr_stat
);
  import rxi_pkg::*;

  logic rdy_rise, err_rise, fs_rise, blk_cross, hit;
  rxi_mode_e sel;

  assign sel = rxi_mode_e'(mode);

  rxi_rise u_rdy (.clk(clk), .rst(rst), .d(rx_ready), .rise(rdy_rise));
  rxi_rise u_err (.clk(clk), .rst(rst), .d(sync_err), .rise(err_rise));

  rxi_fs_sync #(.STAGES(SYNC_STAGES)) u_fs (
    .clk(clk), .rst(rst), .fs_in(fs_async), .fs_rise(fs_rise)
  );

  rxi_blk_mark #(.IDX_W(IDX_W), .BLK_LOG2(BLK_LOG2)) u_blk (
    .clk(clk), .rst(rst), .idx(chan_idx), .crossed(blk_cross)
  );

  always_comb begin
    hit = 1'b0;
    unique case (sel)
      RXI_WORD:  hit = rdy_rise & ~rx_rst;
      RXI_BLOCK: hit = mc_en & ~rx_rst & (blk_cross | eof);
      RXI_FSYNC: hit = fs_rise;
      RXI_ERR:   hit = err_rise & ~rx_rst;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rint      <= 1'b0;
      rdy_stat  <= 1'b0;
      serr_stat <= 1'b0;
    end else begin
      rint      <= hit;
      rdy_stat  <= rx_ready;
      serr_stat <= sync_err;
    end
  end

  p_word_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 && !rx_rst && rx_ready && !$past(rx_ready)) |=> rint);

  p_eof_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && mc_en && !rx_rst && eof) |=> rint);

  p_no_mc_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && !mc_en) |=> !rint);

  p_err_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11 && !rx_rst && sync_err && !$past(sync_err)) |=> rint);

  p_rx_rst_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_rst && mode != 2'b10) |=> !rint);

  p_status_copy_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rdy_stat == $past(rx_ready) && serr_stat == $past(sync_err)));
endmodule

// File: tb/rx_int_sel_test.sv
module rx_int_sel_test;
  localparam int IDX_W = 7;

  logic clk = 1'b0;
  logic rst, rx_rst, rx_ready, sync_err, fs_async, mc_en, eof;
  logic [1:0] mode;
  logic [IDX_W-1:0] chan_idx;
  logic rint, rdy_stat, serr_stat;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag_ovr = "";

  // sampled history, index 0 = most recent edge
  logic [1:0]       h_mode [0:3];
  logic             h_rrst [0:3], h_rdy [0:3], h_err [0:3], h_fs [0:3], h_mc [0:3], h_eof [0:3];
  logic [IDX_W-1:0] h_idx  [0:3];
  logic             h_rst0;

  always #2 clk = ~clk;

  rx_int_sel #(.IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .mode(mode), .rx_rst(rx_rst), .rx_ready(rx_ready),
    .sync_err(sync_err), .fs_async(fs_async), .mc_en(mc_en), .chan_idx(chan_idx),
    .eof(eof), .rint(rint), .rdy_stat(rdy_stat), .serr_stat(serr_stat)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic e;
    string t;
    @(posedge clk);
    for (int i = 3; i > 0; i--) begin
      h_mode[i] = h_mode[i-1]; h_rrst[i] = h_rrst[i-1]; h_rdy[i] = h_rdy[i-1];
      h_err[i] = h_err[i-1]; h_fs[i] = h_fs[i-1]; h_mc[i] = h_mc[i-1];
      h_eof[i] = h_eof[i-1]; h_idx[i] = h_idx[i-1];
    end
    h_mode[0] = mode; h_rrst[0] = rx_rst; h_rdy[0] = rx_ready; h_err[0] = sync_err;
    h_fs[0] = fs_async; h_mc[0] = mc_en; h_eof[0] = eof; h_idx[0] = chan_idx;
    h_rst0 = rst;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        h_rdy[i] = 0; h_err[i] = 0; h_fs[i] = 0; h_idx[i] = '0;
      end
    end
    @(negedge clk);
    if (h_rst0) begin
      chk("R1 rint", rint, 1'b0);
      chk("R1 rdy_stat", rdy_stat, 1'b0);
      chk("R1 serr_stat", serr_stat, 1'b0);
      return;
    end
    e = 1'b0;
    case (h_mode[0])
      2'b00: begin e = !h_rrst[0] && h_rdy[0] && !h_rdy[1]; t = "R2"; end
      2'b01: begin
        e = !h_rrst[0] && h_mc[0] &&
            (h_eof[0] || (h_idx[1][3:0] == 4'hF && h_idx[0] != h_idx[1]));
        t = h_mc[0] ? "R3" : "R4";
      end
      2'b10: begin e = h_fs[2] && !h_fs[3]; t = "R5"; end
      default: begin e = !h_rrst[0] && h_err[0] && !h_err[1]; t = "R6"; end
    endcase
    if (h_rrst[0] && h_mode[0] != 2'b10) t = "R7";
    if (tag_ovr != "") t = tag_ovr;
    chk(t, rint, e);
    chk("R9 rdy_stat", rdy_stat, h_rdy[0]);
    chk("R9 serr_stat", serr_stat, h_err[0]);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      h_mode[i] = 0; h_rrst[i] = 0; h_rdy[i] = 0; h_err[i] = 0;
      h_fs[i] = 0; h_mc[i] = 0; h_eof[i] = 0; h_idx[i] = '0;
    end
    rst = 1; mode = 2'b00; rx_rst = 0; rx_ready = 1; sync_err = 1;
    fs_async = 1; mc_en = 1; eof = 1; chan_idx = 7'd15;
    @(negedge clk);
    step(); step(); step();
    rst = 0; rx_ready = 0; sync_err = 0; fs_async = 0; eof = 0; chan_idx = '0;
    step();

    // random sweep over every mode
    for (int m = 0; m < 4; m++) begin
      mode = m[1:0];
      for (int c = 0; c < 3000; c++) begin
        rx_rst   = ($urandom_range(0, 9) == 0);
        if ($urandom_range(0, 3) == 0) rx_ready = ~rx_ready;
        if ($urandom_range(0, 4) == 0) sync_err = ~sync_err;
        if ($urandom_range(0, 5) == 0) fs_async = ~fs_async;
        mc_en    = (c < 1500) ? 1'b1 : ($urandom_range(0, 1) == 1);
        eof      = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 1) == 1) chan_idx = chan_idx + 1'b1;
        step();
      end
    end

    // R5: frame sync while receiver held in reset, long pulse gives one interrupt
    mode = 2'b10; rx_rst = 1; fs_async = 0;
    repeat (4) step();
    fs_async = 1;
    repeat (8) step();
    fs_async = 0;
    repeat (4) step();

    // R7: release receiver reset with ready already high
    mode = 2'b00; rx_rst = 1; rx_ready = 0; step();
    rx_ready = 1; step(); step();
    rx_rst = 0; tag_ovr = "R7"; step(); step(); tag_ovr = "";

    // R8: edges seen in another mode are not reported after switching
    mode = 2'b10; rx_ready = 0; sync_err = 0; step();
    rx_ready = 1; sync_err = 1; step();
    tag_ovr = "R8";
    mode = 2'b00; step();
    mode = 2'b11; step();
    tag_ovr = "";

    // R3: boundary and end of frame together, then a stall on index 15
    mode = 2'b01; mc_en = 1; eof = 0; chan_idx = 7'd31; step(); step();
    chan_idx = 7'd32; eof = 1; step();
    eof = 0; step();
    chan_idx = 7'd47; step(); step(); step();
    chan_idx = 7'd48; step(); step();

    // R4: multichannel off, boundaries and end of frame ignored
    mc_en = 0; chan_idx = 7'd63; step();
    chan_idx = 7'd64; eof = 1; step();
    eof = 0; step();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule